// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This unit produces the program address of a small microcontroller, one instruction cycle at a time. It holds a 10-bit program counter and a five-entry circular stack of return addresses. A separate two-bit latch holds the upper PC bits that are used when software writes the PC low byte.

Each cycle an already-decoded operation arrives. The operation says whether the PC steps forward, jumps, calls, returns, or takes a new low byte. The instruction's address field and a data byte come with it, and there is an independent write strobe for the upper-bits latch. The current PC and its readable low byte are the outputs.

Jumps, calls and returns never touch the latch. A low-byte write therefore lands in the page that software last set, whatever page the PC is in.

Top module: `pcseq_unit`

## Requirements
- R1: While `rst_n` is low and after it rises, the PC, the upper-bits latch, the stack pointer and every stack entry are zero. `pc_o` reads 0 in the first cycle after reset.
- R2: For op code 0 (step), and for the unused codes 5, 6 and 7, the PC becomes PC+1 at the next clock edge. It wraps from 1023 to 0.
- R3: For op code 1 (jump), the PC becomes `addr_i` at the next edge and the upper-bits latch keeps its value.
- R4: For op code 2 (call), the PC becomes `addr_i` and PC+1 (modulo 1024) is pushed onto the stack.
- R5: For op code 3 (return), the PC becomes the most recently pushed entry that has not yet been popped, and the stack pointer steps back by one.
- R6: For op code 4 (low-byte write), the new PC is {latch[1:0], `data_i`}. The latch value used is the one held before this edge, even if `hi_wr_i` is high in the same cycle.
- R7: The upper-bits latch takes `hi_data_i` only at an edge where `hi_wr_i` is 1. It is never loaded from the PC.
- R8: `pcl_o` always equals PC[7:0].
- R9: The stack is circular. A sixth push without a pop overwrites the oldest entry. A pop from an empty stack returns the entry at the wrapped position (slot 4 after a reset), and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Decoded PC operation: 0 step, 1 jump, 2 call, 3 return, 4 low-byte write |
| addr_i | input | 10 | Address field of jump or call |
| data_i | input | 8 | Byte written to the PC low byte |
| hi_wr_i | input | 1 | Write strobe of the upper-bits latch |
| hi_data_i | input | 2 | Value for the upper-bits latch |
| pc_o | output | 10 | Current program counter |
| pcl_o | output | 8 | Readable PC low byte |

## Verification
A corrupted stack pointer or stack entry stays hidden until a return. It then shows on `pc_o` one cycle after that return, as the wrong address. A latch that drifts, or that was wrongly loaded by a jump, shows only at the next low-byte write, as a wrong upper page. The bench therefore follows deep call chains with matching and surplus returns, and places low-byte writes after jumps. A reference model is compared on every cycle, so any divergence is reported in the cycle it reaches the PC.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int PC_W  = 10;
  localparam int LO_W  = 8;
  localparam int HI_W  = PC_W - LO_W;
  localparam int DEPTH = 5;

  typedef enum logic [2:0] {
    OP_STEP = 3'd0,
    OP_JUMP = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_PCLW = 3'd4
  } pc_op_e;

  function automatic logic [PC_W-1:0] pc_inc(input logic [PC_W-1:0] pc);
    return pc + {{(PC_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic int unsigned ring_up(input int unsigned p, input int unsigned n);
    return (p == n - 1) ? 0 : p + 1;
  endfunction

  function automatic int unsigned ring_dn(input int unsigned p, input int unsigned n);
    return (p == 0) ? n - 1 : p - 1;
  endfunction
endpackage

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int W     = 10,
  parameter int DEPTH = 5,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data
);
  import pcseq_pkg::*;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] sp_q;
  logic [PW-1:0] sp_up, sp_dn;

  assign sp_up    = PW'(ring_up(int'(sp_q), DEPTH));
  assign sp_dn    = PW'(ring_dn(int'(sp_q), DEPTH));
  assign top_data = mem[sp_dn];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (push) begin
      sp_q <= sp_up;
    end else if (pop) begin
      sp_q <= sp_dn;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) mem[i] <= '0;
      else if (push && sp_q == PW'(i)) mem[i] <= push_data;
    end
  end

  p_one_op_r9: assert property (@(posedge clk) disable iff (!rst_n) !(push && pop));
  p_push_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && sp_q == PW'(DEPTH-1)) |=> (sp_q == '0));
  p_pop_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && sp_q == '0) |=> (sp_q == PW'(DEPTH-1)));
  p_push_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (top_data == $past(push_data)));
endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
  import pcseq_pkg::*;
(
  input  logic [2:0]      op,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] addr,
  input  logic [LO_W-1:0] data,
  input  logic [HI_W-1:0] hi_latch,
  input  logic [PC_W-1:0] stack_top,
  output logic [PC_W-1:0] pc_next,
  output logic            push_ev,
  output logic            pop_ev
);
  always_comb begin
    push_ev = 1'b0;
    pop_ev  = 1'b0;
    unique case (op)
      OP_JUMP: pc_next = addr;
      OP_CALL: begin pc_next = addr; push_ev = 1'b1; end
      OP_RET:  begin pc_next = stack_top; pop_ev = 1'b1; end
      OP_PCLW: pc_next = {hi_latch, data};
      default: pc_next = pc_inc(pc);
    endcase
  end
endmodule

// File: rtl/pcseq_unit.sv
module pcseq_unit
  import pcseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op_i,
  input  logic [PC_W-1:0] addr_i,
  input  logic [LO_W-1:0] data_i,
  input  logic            hi_wr_i,
  input  logic [HI_W-1:0] hi_data_i,
  output logic [PC_W-1:0] pc_o,
  output logic [LO_W-1:0] pcl_o
);
  logic [PC_W-1:0] pc_q, pc_next, stack_top;
  logic [HI_W-1:0] hi_q;
  logic            push_ev, pop_ev;

  pcseq_next u_next (
    .op(op_i), .pc(pc_q), .addr(addr_i), .data(data_i), .hi_latch(hi_q),
    .stack_top(stack_top), .pc_next(pc_next), .push_ev(push_ev), .pop_ev(pop_ev)
  );

  pcseq_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push_ev), .pop(pop_ev),
    .push_data(pc_inc(pc_q)), .top_data(stack_top)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0;
      hi_q <= '0;
    end else begin
      pc_q <= pc_next;
      if (hi_wr_i) hi_q <= hi_data_i;
    end
  end

  assign pc_o  = pc_q;
  assign pcl_o = pc_q[LO_W-1:0];

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_STEP) |=> (pc_o == $past(pc_o) + 10'd1));
  p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_JUMP) |=> (pc_o == $past(addr_i)));
  p_call_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CALL) |=> (pc_o == $past(addr_i)));
  p_pclw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_PCLW) |=> (pc_o == {$past(hi_q), $past(data_i)}));
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr_i |=> $stable(hi_q));
  p_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pcl_o == pc_o[7:0]);
endmodule

// File: tb/tb_pcseq_unit.sv
module tb_pcseq_unit;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] op_i = 0;
  logic [9:0] addr_i = 0;
  logic [7:0] data_i = 0;
  logic       hi_wr_i = 0;
  logic [1:0] hi_data_i = 0;
  logic [9:0] pc_o;
  logic [7:0] pcl_o;

  int checks = 0, errors = 0;
  int m_pc = 0, m_hi = 0, m_sp = 0;
  int m_stk [5];

  always #10 clk = ~clk;

  pcseq_unit dut (.*);

  task automatic check(input string tag);
    checks++;
    if (pc_o !== 10'(m_pc)) begin
      errors++;
      $display("FAIL %s pc actual %0d expected %0d", tag, pc_o, m_pc);
    end
    checks++;
    if (pcl_o !== 8'(m_pc)) begin
      errors++;
      $display("FAIL R8 pcl actual %0d expected %0d", pcl_o, m_pc % 256);
    end
  endtask

  task automatic step(input int op, input int addr, input int data,
                      input bit hw, input int hd, input string tag);
    op_i = 3'(op); addr_i = 10'(addr); data_i = 8'(data);
    hi_wr_i = hw; hi_data_i = 2'(hd);
    @(posedge clk);
    case (op)
      1: m_pc = addr;
      2: begin
        m_stk[m_sp] = (m_pc + 1) % 1024;
        m_sp = (m_sp + 1) % 5;
        m_pc = addr;
      end
      3: begin
        m_sp = (m_sp + 4) % 5;
        m_pc = m_stk[m_sp];
      end
      4: m_pc = m_hi * 256 + data;
      default: m_pc = (m_pc + 1) % 1024;
    endcase
    if (hw) m_hi = hd;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    foreach (m_stk[i]) m_stk[i] = 0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1;
    @(negedge clk);
    m_pc = 1;
    check("R1");
    // R9: pop from empty stack right after reset gives slot 4 = 0
    step(3, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, "R2");
    step(5, 0, 0, 0, 0, "R2");
    step(7, 0, 0, 0, 0, "R2");
    step(1, 10'h3FE, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, "R2");
    step(6, 0, 0, 0, 0, "R2");   // wrap to 0
    // R7/R6: latch write and a low-byte write in the same cycle use the old latch
    step(4, 0, 8'h55, 1, 2, "R6");
    step(4, 0, 8'hA7, 0, 0, "R6");
    step(1, 10'h123, 0, 0, 0, "R3");
    step(4, 0, 8'h0F, 0, 0, "R7");  // latch unchanged by the jump
    step(1, 10'h3C0, 0, 1, 1, "R7");
    step(4, 0, 8'hEE, 0, 0, "R7");
    // R4/R5: nested calls and matching returns
    step(2, 10'h100, 0, 0, 0, "R4");
    step(2, 10'h200, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, "R2");
    step(3, 0, 0, 0, 0, "R5");
    step(3, 0, 0, 0, 0, "R5");
    // R9: six calls overwrite the oldest entry, then six returns
    for (int i = 0; i < 6; i++) step(2, 40 * i + 7, 0, 0, 0, "R9");
    for (int i = 0; i < 6; i++) step(3, 0, 0, 0, 0, "R9");
    step(2, 10'h3FF, 0, 0, 0, "R4");
    step(3, 0, 0, 0, 0, "R5");
    // R1: reset in mid-run
    rst_n = 0;
    @(posedge clk);
    m_pc = 0; m_hi = 0; m_sp = 0;
    foreach (m_stk[i]) m_stk[i] = 0;
    @(negedge clk);
    check("R1");
    rst_n = 1;
    op_i = 3'd4; data_i = 8'h33;
    @(posedge clk);
    m_pc = 8'h33;
    @(negedge clk);
    check("R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule